// File: doc/BRIEF.md
# Doorbell Routing Table with Pending Replay

This block sits behind the host doorbell aperture. Each doorbell write carries an offset and a 64-bit value. The block looks the offset up in a small fully associative table that software programs. On a hit, the write goes out on a single dispatch port, tagged with the destination queue class and engine number. The value is adjusted for the classes that need it.

A write to an offset that has no table entry is still accepted. It is parked in a pending buffer keyed by that offset. Software later registers the mapping and pulses a replay strobe that names the offset. The parked value then leaves through the same dispatch port and its slot is freed.

A bulk command removes every mapping in the user doorbell range, which is every offset at or above a threshold parameter. Mappings below the threshold are kept.

Top module: `doorbell_router`

## Requirements
- R1: After reset, `dispValid` and `overflowErr` are low, and the table and the pending buffer are empty, so the first doorbell write to any offset is parked rather than dispatched.
- R2: A doorbell write whose offset has a table entry produces, one clock later, a single-cycle `dispValid` with that entry's `dispType` and `dispEngine`. A mapping command to an offset that is already mapped overwrites its type and engine. A table change takes effect for writes on later cycles.
- R3: The queue class is encoded as follows: 0 compute, 1 graphics, 2 DMA-graphics, 3 DMA-page, 4 compute-AQL, 5 interrupt-handler, 6 RLC. For classes 0, 1, 2, 3 and 6, `dispData` equals the written value unchanged.
- R4: For class 4 (compute-AQL), `dispData` is the written value plus one, wrapping modulo 2^64.
- R5: For class 5 (interrupt-handler), `dispData` carries the low 32 bits of the value, with bits 63:32 forced to zero.
- R6: A doorbell write to an unmapped offset raises neither `dispValid` nor `overflowErr`. Its value is held in the pending buffer.
- R7: A replay strobe for an offset that is both pending and mapped dispatches the parked value one clock later, with R3 to R5 applied, and frees the slot. A second replay strobe for the same offset then has no effect.
- R8: A replay strobe for an offset that is not pending, or that is pending but still unmapped, has no effect. In the second case the parked value stays in the buffer.
- R9: A second unmapped write to an offset that is already pending replaces the parked value and uses no extra slot.
- R10: When all PEND_N slots hold other offsets, an unmapped write to a new offset is dropped and `overflowErr` pulses high for one cycle, one clock later.
- R11: The unmap-user command invalidates every table entry whose offset is at or above USER_BASE (default 0x4000) and keeps every entry below it.
- R12: When a doorbell write and a replay strobe arrive in the same cycle, the doorbell write is served and the replay strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mapValid | input | 1 | Register or overwrite one table entry |
| mapOffset | input | OFF_W | Doorbell offset of the entry |
| mapType | input | 3 | Queue class code (R3) |
| mapEngine | input | ENG_W | Engine number |
| unmapUser | input | 1 | Remove all mappings at or above USER_BASE |
| dbValid | input | 1 | Doorbell write strobe |
| dbOffset | input | OFF_W | Doorbell write offset |
| dbData | input | 64 | Doorbell write value |
| replayValid | input | 1 | Replay the parked write for an offset |
| replayOffset | input | OFF_W | Offset to replay |
| dispValid | output | 1 | Routed write valid (one cycle) |
| dispType | output | 3 | Queue class of the routed write |
| dispEngine | output | ENG_W | Engine number of the routed write |
| dispData | output | 64 | Adjusted value of the routed write |
| overflowErr | output | 1 | Pulses when a write is dropped because the pending buffer is full |

## Verification
The hardest state to reach is a full pending buffer. Getting there takes eight distinct unmapped offsets while no replay drains any of them. The stimulus parks writes to fresh offsets until a ninth is refused, then maps and replays all of them to empty the buffer again. A second hard case is a parked offset that is remapped or unmapped before its replay. The bench builds this by parking values, changing the table, including a bulk unmap across the user threshold, and only then strobing replay. The behavioural model predicts whether each replay dispatches or stays parked.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [2:0] {
    QT_COMPUTE  = 3'd0,
    QT_GFX      = 3'd1,
    QT_DMA_GFX  = 3'd2,
    QT_DMA_PAGE = 3'd3,
    QT_AQL      = 3'd4,
    QT_IH       = 3'd5,
    QT_RLC      = 3'd6,
    QT_RSVD     = 3'd7
  } qtype_e;

  typedef struct packed {
    logic fwdLive;    // doorbell write hits the table
    logic fwdParked;  // replay of a parked value
    logic park;       // store unmapped write
    logic overflow;   // unmapped write dropped
  } dbr_strobe_t;
endpackage

// File: rtl/dbr_table.sv
module dbr_table #(
  parameter int OFF_W     = 16,
  parameter int ENG_W     = 4,
  parameter int TAB_N     = 32,
  parameter int USER_BASE = 'h4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mapValid,
  input  logic [OFF_W-1:0] mapOffset,
  input  logic [2:0]       mapType,
  input  logic [ENG_W-1:0] mapEngine,
  input  logic             unmapUser,
  input  logic [OFF_W-1:0] lookOffset,
  output logic             hit,
  output logic [2:0]       hitType,
  output logic [ENG_W-1:0] hitEngine
);
  localparam logic [OFF_W-1:0] USER_LIM = OFF_W'(USER_BASE);

  logic [TAB_N-1:0] vld;
  logic [OFF_W-1:0] tag [TAB_N];
  logic [2:0]       typ [TAB_N];
  logic [ENG_W-1:0] eng [TAB_N];
  logic [TAB_N-1:0] lookMatch, mapMatch, freeSel, wrSel;

  for (genvar i = 0; i < TAB_N; i++) begin : g_cmp
    assign lookMatch[i] = vld[i] && (tag[i] == lookOffset);
    assign mapMatch[i]  = vld[i] && (tag[i] == mapOffset);
  end

  always_comb begin
    freeSel = '0;
    for (int i = TAB_N - 1; i >= 0; i--) begin
      if (!vld[i]) freeSel = TAB_N'(1) << i;
    end
    wrSel = (|mapMatch) ? mapMatch : freeSel;
  end

  always_comb begin
    hitType   = '0;
    hitEngine = '0;
    for (int i = 0; i < TAB_N; i++) begin
      if (lookMatch[i]) begin
        hitType   = hitType | typ[i];
        hitEngine = hitEngine | eng[i];
      end
    end
    hit = |lookMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < TAB_N; i++) begin
        if (mapValid && wrSel[i])                  vld[i] <= 1'b1;
        else if (unmapUser && tag[i] >= USER_LIM) vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < TAB_N; i++) begin
      if (mapValid && wrSel[i]) begin
        tag[i] <= mapOffset;
        typ[i] <= mapType;
        eng[i] <= mapEngine;
      end
    end
  end
endmodule

// File: rtl/dbr_pending.sv
module dbr_pending #(
  parameter int OFF_W  = 16,
  parameter int DATA_W = 64,
  parameter int PEND_N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              park,
  input  logic              release_,
  input  logic [OFF_W-1:0]  lookOffset,
  input  logic [DATA_W-1:0] wrData,
  output logic              pendHit,
  output logic              pendFull,
  output logic [DATA_W-1:0] pendData
);
  logic [PEND_N-1:0] vld;
  logic [OFF_W-1:0]  key  [PEND_N];
  logic [DATA_W-1:0] val  [PEND_N];
  logic [PEND_N-1:0] hitVec, freeSel, wrSel;

  for (genvar i = 0; i < PEND_N; i++) begin : g_cmp
    assign hitVec[i] = vld[i] && (key[i] == lookOffset);
  end

  always_comb begin
    freeSel  = '0;
    pendData = '0;
    for (int i = PEND_N - 1; i >= 0; i--) begin
      if (!vld[i]) freeSel = PEND_N'(1) << i;
    end
    for (int i = 0; i < PEND_N; i++) begin
      if (hitVec[i]) pendData = pendData | val[i];
    end
    wrSel    = (|hitVec) ? hitVec : freeSel;
    pendHit  = |hitVec;
    pendFull = &vld;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < PEND_N; i++) begin
        if (park && wrSel[i])           vld[i] <= 1'b1;
        else if (release_ && hitVec[i]) vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PEND_N; i++) begin
      if (park && wrSel[i]) begin
        key[i] <= lookOffset;
        val[i] <= wrData;
      end
    end
  end
endmodule

// File: rtl/dbr_ctrl.sv
module dbr_ctrl (
  input  logic                dbValid,
  input  logic                replayValid,
  input  logic                tabHit,
  input  logic                pendHit,
  input  logic                pendFull,
  output dbr_pkg::dbr_strobe_t stb
);
  always_comb begin
    stb           = '0;
    stb.fwdLive   = dbValid && tabHit;
    stb.park      = dbValid && !tabHit && (pendHit || !pendFull);
    stb.overflow  = dbValid && !tabHit && !pendHit && pendFull;
    stb.fwdParked = !dbValid && replayValid && tabHit && pendHit;
  end
endmodule

// File: rtl/doorbell_router.sv
module doorbell_router #(
  parameter int OFF_W     = 16,
  parameter int ENG_W     = 4,
  parameter int TAB_N     = 32,
  parameter int PEND_N    = 8,
  parameter int USER_BASE = 'h4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mapValid,
  input  logic [OFF_W-1:0] mapOffset,
  input  logic [2:0]       mapType,
  input  logic [ENG_W-1:0] mapEngine,
  input  logic             unmapUser,
  input  logic             dbValid,
  input  logic [OFF_W-1:0] dbOffset,
  input  logic [63:0]      dbData,
  input  logic             replayValid,
  input  logic [OFF_W-1:0] replayOffset,
  output logic             dispValid,
  output logic [2:0]       dispType,
  output logic [ENG_W-1:0] dispEngine,
  output logic [63:0]      dispData,
  output logic             overflowErr
);
  import dbr_pkg::*;

  logic [OFF_W-1:0] lookOffset;
  logic             tabHit, pendHit, pendFull;
  logic [2:0]       hitType;
  logic [ENG_W-1:0] hitEngine;
  logic [63:0]      pendData, srcData, fwdData;
  dbr_strobe_t      stb;

  assign lookOffset = dbValid ? dbOffset : replayOffset;

  dbr_table #(.OFF_W(OFF_W), .ENG_W(ENG_W), .TAB_N(TAB_N), .USER_BASE(USER_BASE)) u_table (
    .clk(clk), .rstN(rstN), .mapValid(mapValid), .mapOffset(mapOffset),
    .mapType(mapType), .mapEngine(mapEngine), .unmapUser(unmapUser),
    .lookOffset(lookOffset), .hit(tabHit), .hitType(hitType), .hitEngine(hitEngine)
  );

  dbr_pending #(.OFF_W(OFF_W), .DATA_W(64), .PEND_N(PEND_N)) u_pend (
    .clk(clk), .rstN(rstN), .park(stb.park), .release_(stb.fwdParked),
    .lookOffset(lookOffset), .wrData(dbData), .pendHit(pendHit),
    .pendFull(pendFull), .pendData(pendData)
  );

  dbr_ctrl u_ctrl (
    .dbValid(dbValid), .replayValid(replayValid), .tabHit(tabHit),
    .pendHit(pendHit), .pendFull(pendFull), .stb(stb)
  );

  always_comb begin
    srcData = stb.fwdLive ? dbData : pendData;
    case (qtype_e'(hitType))
      QT_AQL:  fwdData = srcData + 64'd1;
      QT_IH:   fwdData = {32'd0, srcData[31:0]};
      default: fwdData = srcData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispValid   <= 1'b0;
      dispType    <= '0;
      dispEngine  <= '0;
      dispData    <= '0;
      overflowErr <= 1'b0;
    end else begin
      dispValid   <= stb.fwdLive || stb.fwdParked;
      dispType    <= hitType;
      dispEngine  <= hitEngine;
      dispData    <= fwdData;
      overflowErr <= stb.overflow;
    end
  end
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dbValid,
  input logic [63:0]          dbData,
  input logic                 replayValid,
  input logic                 dispValid,
  input logic [2:0]           dispType,
  input logic [63:0]          dispData,
  input logic                 overflowErr,
  input dbr_pkg::dbr_strobe_t stb
);
  // R2: a dispatch needs a write or replay one cycle earlier
  p_disp_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> $past(dbValid || replayValid));

  // R4: AQL forwards the written value plus one
  p_aql_incr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispType == 3'd4 && $past(stb.fwdLive)) |-> dispData == $past(dbData) + 64'd1);

  // R5: interrupt-handler class carries only 32 bits
  p_ih_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispType == 3'd5) |-> dispData[63:32] == 32'd0);

  // R10: overflow only follows a doorbell write and never with a dispatch
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |-> ($past(dbValid) && !dispValid));

  // R12: with a write and a replay together, the write's value goes out
  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && $past(dbValid) && $past(replayValid) && dispType != 3'd4 && dispType != 3'd5)
      |-> dispData == $past(dbData));
endmodule

bind doorbell_router dbr_checker u_chk (
  .clk(clk), .rstN(rstN), .dbValid(dbValid), .dbData(dbData),
  .replayValid(replayValid), .dispValid(dispValid), .dispType(dispType),
  .dispData(dispData), .overflowErr(overflowErr), .stb(stb)
);

// File: tb/doorbell_router_tb.sv
module doorbell_router_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mapValid = 0, unmapUser = 0, dbValid = 0, replayValid = 0;
  logic [15:0] mapOffset = 0, dbOffset = 0, replayOffset = 0;
  logic [2:0]  mapType = 0;
  logic [3:0]  mapEngine = 0;
  logic [63:0] dbData = 0;
  logic        dispValid, overflowErr;
  logic [2:0]  dispType;
  logic [3:0]  dispEngine;
  logic [63:0] dispData;

  int checks = 0, fails = 0;
  bit done = 0;

  int              mType [int];
  int              mEng  [int];
  logic [63:0]     pend  [int];

  always #5 clk = ~clk;

  doorbell_router u_dut (
    .clk(clk), .rstN(rstN), .mapValid(mapValid), .mapOffset(mapOffset),
    .mapType(mapType), .mapEngine(mapEngine), .unmapUser(unmapUser),
    .dbValid(dbValid), .dbOffset(dbOffset), .dbData(dbData),
    .replayValid(replayValid), .replayOffset(replayOffset),
    .dispValid(dispValid), .dispType(dispType), .dispEngine(dispEngine),
    .dispData(dispData), .overflowErr(overflowErr)
  );

  function automatic logic [63:0] adjust(int t, logic [63:0] d);
    if (t == 4) return d + 64'd1;
    if (t == 5) return {32'd0, d[31:0]};
    return d;
  endfunction

  task automatic cyc(input bit dv, input int doff, input logic [63:0] dd,
                     input bit rv, input int roff,
                     input bit mv, input int moff, input int mt, input int me,
                     input bit um, input string tag);
    bit expV = 0, expO = 0;
    int expT = 0, expE = 0;
    logic [63:0] expD = 0;
    int drop [$];
    dbValid = dv; dbOffset = 16'(doff); dbData = dd;
    replayValid = rv; replayOffset = 16'(roff);
    mapValid = mv; mapOffset = 16'(moff); mapType = 3'(mt); mapEngine = 4'(me);
    unmapUser = um;
    if (dv) begin
      if (mType.exists(doff)) begin
        expV = 1; expT = mType[doff]; expE = mEng[doff]; expD = adjust(expT, dd);
      end else if (pend.exists(doff) || pend.num() < 8) begin
        pend[doff] = dd;
      end else begin
        expO = 1;
      end
    end else if (rv && pend.exists(roff) && mType.exists(roff)) begin
      expV = 1; expT = mType[roff]; expE = mEng[roff]; expD = adjust(expT, pend[roff]);
      pend.delete(roff);
    end
    if (um) begin
      foreach (mType[k]) if (k >= 'h4000) drop.push_back(k);
      foreach (drop[j]) begin mType.delete(drop[j]); mEng.delete(drop[j]); end
    end
    if (mv) begin mType[moff] = mt; mEng[moff] = me; end
    @(posedge clk);
    @(negedge clk);
    dbValid = 0; replayValid = 0; mapValid = 0; unmapUser = 0;
    checks++;
    if (dispValid !== expV || overflowErr !== expO ||
        (expV && (dispType !== 3'(expT) || dispEngine !== 4'(expE) || dispData !== expD))) begin
      fails++;
      $display("FAIL %s: act v=%0b o=%0b t=%0d e=%0d d=%h exp v=%0b o=%0b t=%0d e=%0d d=%h",
               tag, dispValid, overflowErr, dispType, dispEngine, dispData,
               expV, expO, expT, expE, expD);
    end
  endtask

  task automatic dbw(input int off, input logic [63:0] d, input string tag);
    cyc(1, off, d, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rep(input int off, input string tag);
    cyc(0, 0, 0, 1, off, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic mapq(input int off, input int t, input int e, input string tag);
    cyc(0, 0, 0, 0, 0, 1, off, t, e, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act hung exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (dispValid !== 1'b0 || overflowErr !== 1'b0) begin
      fails++;
      $display("FAIL R1: act v=%0b o=%0b exp 0 0", dispValid, overflowErr);
    end
    dbw('h10, 64'h1234, "R1");
    dbw('h10, 64'h5678, "R9");
    mapq('h10, 0, 3, "R2");
    rep('h10, "R7");
    rep('h10, "R7");
    dbw('h10, 64'hDEAD_0000_BEEF, "R2");
    mapq('h10, 1, 7, "R2");
    dbw('h10, 64'h77, "R2");
    mapq('h20, 4, 1, "R4");
    dbw('h20, 64'd5, "R4");
    dbw('h20, '1, "R4");
    mapq('h30, 5, 2, "R5");
    dbw('h30, 64'hAAAA_BBBB_CCCC_DDDD, "R5");
    for (int t = 0; t < 7; t++) begin
      mapq('h40 + t, t, 8 + t, "R3");
      dbw('h40 + t, 64'hF0F0_0000_0000_0000 + 64'(t), "R3");
    end
    rep('h99, "R8");
    dbw('h50, 64'h50, "R6");
    rep('h50, "R8");
    mapq('h50, 4, 5, "R8");
    rep('h50, "R7");
    dbw('h60, 64'h1, "R9");
    dbw('h60, 64'h2, "R9");
    mapq('h60, 6, 6, "R9");
    rep('h60, "R9");
    rep('h60, "R9");
    for (int i = 0; i < 8; i++) dbw('h100 + i, 64'(i) + 64'h100, "R6");
    dbw('h108, 64'hBAD, "R10");
    dbw('h103, 64'hABC, "R9");
    for (int i = 0; i < 9; i++) begin
      mapq('h100 + i, 5, 3, "R10");
      rep('h100 + i, "R10");
    end
    mapq('h3FFF, 2, 4, "R11");
    mapq('h4000, 3, 9, "R11");
    mapq('h4100, 1, 10, "R11");
    dbw('h4000, 64'h11, "R11");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
    dbw('h3FFF, 64'h22, "R11");
    dbw('h4000, 64'h33, "R11");
    dbw('h4100, 64'h44, "R11");
    rep('h4000, "R8");
    mapq('h4000, 0, 1, "R11");
    rep('h4000, "R11");
    dbw('h70, 64'h70, "R12");
    mapq('h70, 0, 2, "R12");
    mapq('h71, 1, 3, "R12");
    cyc(1, 'h71, 64'h7171, 1, 'h70, 0, 0, 0, 0, 0, "R12");
    rep('h70, "R12");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule